// File: doc/BRIEF.md
# UART Host Register Interface

This block is the processor-facing register front end of a 16550-compatible serial port. A host reaches eight byte-wide registers through a 3-bit offset, a write strobe and a read strobe. Bit 7 of the line control register is the divisor-latch access bit. When that bit is set, offsets 0 and 1 reach the two bytes of the baud divisor instead of the data and interrupt-enable registers. The divisor is only stored here and handed to the baud generator.

The data path is double-buffered on both sides. Host writes to offset 0 enter a transmit holding queue. The serializer drains that queue through a valid/ready byte handshake. Bytes finished by the receive shifter arrive as one-cycle pulses and enter a receive queue. The host pops that queue by reading offset 0.

Both queues are 16 bytes deep when FIFO mode is on. They shrink to a single byte when FIFO mode is off. A write to the FIFO control register with bit 0 cleared turns FIFO mode off and empties both queues. So does any write that changes the mode. The interrupt output combines four pending conditions, each masked by its enable bit. The status bits underneath keep updating whatever the enables say.

Top module: `uart_host_regs`

## Requirements
- R1: With the access bit (LCR bit 7) at 0, a write to offset 0 pushes the byte into the transmit holding queue. A read of offset 0 returns the oldest received byte and removes it from the queue.
- R2: With LCR bit 7 at 1, offset 0 reads and writes divisor bits 7:0 and offset 1 reads and writes divisor bits 15:8. The 16-bit value appears on `divisor`. Such accesses leave the transmit queue and the interrupt enables untouched.
- R3: Offset 1 with LCR bit 7 at 0 stores the four interrupt enables in bits 3:0. Bits 7:4 always read back as 0.
- R4: `irq` is the OR of four terms, each an enable bit ANDed with its pending condition. Bit 0 pairs with receive data available. Bit 1 pairs with transmit holding empty. Bit 2 pairs with a line error (overrun or `rx_err`). Bit 3 pairs with `modem_pend`. With all four enables at 0, `irq` stays 0 while the line status bits still update.
- R5: Offset 2 is write-only FIFO control whatever the access bit is. A read of offset 2 returns identification: bits 7:6 are 11 in FIFO mode and 00 otherwise, bit 0 is 0 while `irq` is active and 1 otherwise, and all other bits are 0.
- R6: A FIFO control write with bit 0 = 1 enables 16-deep queues. A write with bit 0 = 0 disables them. A write with bit 0 = 0, or one that changes the mode, empties both queues.
- R7: The receive trigger field (FIFO control bits 7:6; 00→1, 01→4, 10→8, 11→14 bytes) is latched from a write in which bit 0 is 1. In FIFO mode, receive data available is pending while the receive queue holds at least the trigger count.
- R8: Outside FIFO mode each queue holds one byte. A received byte that finds the receive queue full is discarded and sets the overrun flag (LSR bit 1). Writing to a full transmit queue is dropped.
- R9: `tx_valid` is high while the transmit queue is non-empty, and `tx_data` shows its oldest byte. A byte leaves on a cycle with `tx_valid` and `tx_ready` both high. Bytes leave in the order written.
- R10: Transmit-holding-empty pending is cleared by a data write at offset 0. It is set again when the transmit queue drains to empty or is flushed. It is 1 after reset.
- R11: The line status register at offset 5 has these bits: bit 0 is data ready (receive queue non-empty), bit 1 is overrun, bit 2 is set by an `rx_err` pulse, and bit 5 is set while the transmit queue is empty. A read returns the current value and then clears bits 1 and 2.
- R12: Synchronous reset clears IER, LCR, the divisor, FIFO mode, the trigger and both queues. Offset 5 then reads 0x20 and offset 2 reads 0x01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 3 | Register offset |
| reg_wr | input | 1 | Write strobe, one cycle per access |
| reg_rd | input | 1 | Read strobe, one cycle per access |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the current offset |
| tx_data | output | 8 | Oldest byte in the transmit queue |
| tx_valid | output | 1 | Transmit queue non-empty |
| tx_ready | input | 1 | Shifter takes `tx_data` this cycle |
| rx_data | input | 8 | Byte completed by the receive shifter |
| rx_valid | input | 1 | `rx_data` is valid this cycle |
| rx_err | input | 1 | Parity, framing or break seen on the current byte |
| modem_pend | input | 1 | Modem status change pending |
| divisor | output | 16 | Stored baud divisor |
| irq | output | 1 | Serial port interrupt request |

## Verification
Register writes, queue pushes and pops, and flag updates all take effect at the clock edge that samples the strobe. `reg_rdata` is combinational from the offset and the current state, so a read returns its value in the same cycle as the strobe, and any pop or clear it causes is visible from the next cycle on. `irq`, `tx_valid` and the status bits are combinational from registered state, so each is due one edge after the stimulus that causes it. The bench drives every access from one falling edge to the next. It samples read data 1 ns into the strobe cycle and samples all other outputs at the falling edge that follows the active edge, so every comparison sees exactly one update.

// File: rtl/uart_host_pkg.sv
package uart_host_pkg;

    localparam int DATA_W     = 8;
    localparam int ADDR_W     = 3;
    localparam int FIFO_DEPTH = 16;
    localparam int CNT_W      = $clog2(FIFO_DEPTH) + 1;
    localparam int DIV_W      = 2 * DATA_W;
    localparam int IRQ_N      = 4;

    typedef enum logic [ADDR_W-1:0] {
        OFS_DATA  = 3'd0,
        OFS_IER   = 3'd1,
        OFS_FCTL  = 3'd2,
        OFS_LCTL  = 3'd3,
        OFS_MCTL  = 3'd4,
        OFS_LSTAT = 3'd5,
        OFS_MSTAT = 3'd6,
        OFS_SCR   = 3'd7
    } reg_ofs_e;

    typedef struct packed {
        logic modem;
        logic line;
        logic thre;
        logic rda;
    } irq_vec_t;

    function automatic logic [CNT_W-1:0] trig_depth(input logic [1:0] code);
        case (code)
            2'd0:    return CNT_W'(1);
            2'd1:    return CNT_W'(4);
            2'd2:    return CNT_W'(8);
            default: return CNT_W'(14);
        endcase
    endfunction

endpackage

// File: rtl/uart_byte_fifo.sv
module uart_byte_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic [CNT_W-1:0] cap,
    input  logic             push,
    input  logic [W-1:0]     din,
    input  logic             pop,
    output logic [W-1:0]     dout,
    output logic [CNT_W-1:0] count,
    output logic             accepted
);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] rd_ptr, wr_ptr;
    logic             pop_ok;

    assign pop_ok   = pop && (count != '0) && !flush;
    assign accepted = push && !flush && ((count < cap) || pop_ok);
    assign dout     = mem[rd_ptr];

    function automatic logic [PTR_W-1:0] next_ptr(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (accepted) begin
                mem[wr_ptr] <= din;
                wr_ptr      <= next_ptr(wr_ptr);
            end
            if (pop_ok) rd_ptr <= next_ptr(rd_ptr);
            case ({accepted, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    AST_COUNT_WITHIN_CAP: assert property (@(posedge clk) disable iff (rst)
        count <= cap); // R8

    AST_REJECT_KEEPS_COUNT: assert property (@(posedge clk) disable iff (rst)
        (push && !accepted && !pop && !flush) |=> $stable(count)); // R8

endmodule

// File: rtl/uart_irq_mask.sv
module uart_irq_mask
    import uart_host_pkg::*;
(
    input  logic [IRQ_N-1:0] enable,
    input  irq_vec_t         pending,
    output logic             irq
);

    logic [IRQ_N-1:0] pend_bits;
    logic [IRQ_N-1:0] hit;

    assign pend_bits = pending;

    for (genvar i = 0; i < IRQ_N; i++) begin : g_src
        assign hit[i] = enable[i] & pend_bits[i];
    end

    assign irq = |hit;

endmodule

// File: rtl/uart_host_regs.sv
module uart_host_regs
    import uart_host_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [DATA_W-1:0] tx_data,
    output logic              tx_valid,
    input  logic              tx_ready,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_valid,
    input  logic              rx_err,
    input  logic              modem_pend,
    output logic [DIV_W-1:0]  divisor,
    output logic              irq
);

    reg_ofs_e          ofs;
    logic [IRQ_N-1:0]  ier_q;
    logic [DATA_W-1:0] lcr_q;
    logic [DIV_W-1:0]  div_q;
    logic              fifo_en_q;
    logic [1:0]        trig_q;
    logic              overrun_q, err_q, thre_q;
    logic              dlab;
    logic              thr_push, rx_pop, tx_pop, fcr_wr, lsr_rd, fifo_flush;
    logic [CNT_W-1:0]  cap, tx_count, rx_count;
    logic [DATA_W-1:0] rx_head;
    logic              tx_acc, rx_acc;
    irq_vec_t          pend;

    assign ofs      = reg_ofs_e'(reg_addr);
    assign dlab     = lcr_q[DATA_W-1];
    assign thr_push = reg_wr && (ofs == OFS_DATA) && !dlab;
    assign rx_pop   = reg_rd && (ofs == OFS_DATA) && !dlab;
    assign fcr_wr   = reg_wr && (ofs == OFS_FCTL);
    assign lsr_rd   = reg_rd && (ofs == OFS_LSTAT);
    assign tx_valid = (tx_count != '0);
    assign tx_pop   = tx_valid && tx_ready;
    // flush on a disabling write and on any mode change
    assign fifo_flush = fcr_wr && !(reg_wdata[0] && fifo_en_q);
    assign cap        = fifo_en_q ? CNT_W'(FIFO_DEPTH) : CNT_W'(1);
    assign divisor    = div_q;

    uart_byte_fifo #(.DEPTH(FIFO_DEPTH), .W(DATA_W)) u_tx_q (
        .clk(clk), .rst(rst), .flush(fifo_flush), .cap(cap),
        .push(thr_push), .din(reg_wdata), .pop(tx_pop),
        .dout(tx_data), .count(tx_count), .accepted(tx_acc)
    );

    uart_byte_fifo #(.DEPTH(FIFO_DEPTH), .W(DATA_W)) u_rx_q (
        .clk(clk), .rst(rst), .flush(fifo_flush), .cap(cap),
        .push(rx_valid), .din(rx_data), .pop(rx_pop),
        .dout(rx_head), .count(rx_count), .accepted(rx_acc)
    );

    always_comb begin
        pend.rda   = fifo_en_q ? (rx_count >= trig_depth(trig_q)) : (rx_count != '0);
        pend.thre  = thre_q;
        pend.line  = overrun_q | err_q;
        pend.modem = modem_pend;
    end

    uart_irq_mask u_irq (
        .enable(ier_q), .pending(pend), .irq(irq)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ier_q     <= '0;
            lcr_q     <= '0;
            div_q     <= '0;
            fifo_en_q <= 1'b0;
            trig_q    <= 2'd0;
            overrun_q <= 1'b0;
            err_q     <= 1'b0;
            thre_q    <= 1'b1;
        end else begin
            if (reg_wr) begin
                case (ofs)
                    OFS_DATA: if (dlab) div_q[DATA_W-1:0] <= reg_wdata;
                    OFS_IER: begin
                        if (dlab) div_q[DIV_W-1:DATA_W] <= reg_wdata;
                        else      ier_q <= reg_wdata[IRQ_N-1:0];
                    end
                    OFS_FCTL: begin
                        fifo_en_q <= reg_wdata[0];
                        if (reg_wdata[0]) trig_q <= reg_wdata[7:6];
                    end
                    OFS_LCTL: lcr_q <= reg_wdata;
                    default: ;
                endcase
            end
            if (lsr_rd) begin
                overrun_q <= 1'b0;
                err_q     <= 1'b0;
            end
            if (rx_valid && !rx_acc && !fifo_flush) overrun_q <= 1'b1;
            if (rx_err) err_q <= 1'b1;
            if (thr_push)
                thre_q <= 1'b0;
            else if (fifo_flush || (tx_pop && tx_count == CNT_W'(1)))
                thre_q <= 1'b1;
        end
    end

    always_comb begin
        case (ofs)
            OFS_DATA:  reg_rdata = dlab ? div_q[DATA_W-1:0] : rx_head;
            OFS_IER:   reg_rdata = dlab ? div_q[DIV_W-1:DATA_W]
                                        : {{(DATA_W-IRQ_N){1'b0}}, ier_q};
            OFS_FCTL:  reg_rdata = {fifo_en_q, fifo_en_q, 5'b0, !irq};
            OFS_LCTL:  reg_rdata = lcr_q;
            OFS_LSTAT: reg_rdata = {2'b0, (tx_count == '0), 2'b0, err_q, overrun_q,
                                    (rx_count != '0)};
            default:   reg_rdata = '0;
        endcase
    end

    AST_THR_WRITE_CLEARS_THRE: assert property (@(posedge clk) disable iff (rst)
        thr_push |=> !thre_q); // R10

    AST_FCR_OFF_FLUSHES: assert property (@(posedge clk) disable iff (rst)
        (fcr_wr && !reg_wdata[0]) |=> (!tx_valid && rx_count == '0)); // R6

    AST_IER_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && ofs == OFS_IER && !dlab) |-> (reg_rdata[7:4] == 4'h0)); // R3

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
        (ier_q == '0) |-> !irq); // R4

    AST_OVERRUN_ON_FULL: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !rx_acc && !fifo_flush) |=> overrun_q); // R8

    AST_TX_HEAD_HELD: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready && !fifo_flush) |=> (tx_valid && $stable(tx_data))); // R9

    AST_DLAB_NO_PUSH: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && ofs == OFS_DATA && dlab && !tx_pop) |=> $stable(tx_count)); // R2

endmodule

// File: tb/test_uart_host_regs.sv
`timescale 1ns/1ps
module test_uart_host_regs;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] reg_addr = '0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [7:0] tx_data;
    logic       tx_valid;
    logic       tx_ready = 1'b0;
    logic [7:0] rx_data = '0;
    logic       rx_valid = 1'b0, rx_err = 1'b0, modem_pend = 1'b0;
    logic [15:0] divisor;
    logic       irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    uart_host_regs i_uart_host_regs (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_data(tx_data),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_data(rx_data),
        .rx_valid(rx_valid), .rx_err(rx_err), .modem_pend(modem_pend),
        .divisor(divisor), .irq(irq)
    );

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic rx_push(input logic [7:0] d);
        @(negedge clk);
        rx_data = d; rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic tx_take(output logic [7:0] d);
        @(negedge clk);
        tx_ready = 1'b1;
        #1 d = tx_data;
        @(negedge clk);
        tx_ready = 1'b0;
    endtask

    function automatic int trig_of(input int code);
        case (code)
            0: return 1;
            1: return 4;
            2: return 8;
            default: return 14;
        endcase
    endfunction

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R12 reset state
        rd(3'd5, v); check("R12 lsr", v, 16'h20);
        rd(3'd2, v); check("R12 iir", v, 16'h01);
        rd(3'd1, v); check("R12 ier", v, 16'h00);
        check("R12 irq", irq, 0);
        check("R12 tx_valid", tx_valid, 0);
        check("R12 divisor", divisor, 16'h0000);

        // R3 full sweep of IER writes
        for (int i = 0; i < 256; i++) begin
            wr(3'd1, 8'(i));
            rd(3'd1, v);
            check("R3 ier readback", v, 16'(i & 8'h0F));
        end
        wr(3'd1, 8'h00);

        // R2 divisor access
        wr(3'd3, 8'h83);
        for (int i = 0; i < 8; i++) begin
            logic [15:0] d;
            d = 16'(i * 4099 + 257);
            wr(3'd0, d[7:0]);
            wr(3'd1, d[15:8]);
            check("R2 divisor port", divisor, d);
            rd(3'd0, v); check("R2 dll read", v, 16'(d[7:0]));
            rd(3'd1, v); check("R2 dlm read", v, 16'(d[15:8]));
        end
        check("R2 no tx push", tx_valid, 0);
        // R5 FCR reachable with access bit set: enable FIFO
        wr(3'd2, 8'h01);
        rd(3'd2, v); check("R5 iir fifo on", v, 16'hC1);
        wr(3'd3, 8'h03);
        rd(3'd1, v); check("R2 ier untouched", v, 16'h00);
        wr(3'd2, 8'h00);
        rd(3'd2, v); check("R5 iir fifo off", v, 16'h01);

        // R1 R8 R9 non-FIFO single byte
        wr(3'd0, 8'h5A);
        check("R1 tx_valid", tx_valid, 1);
        check("R9 tx_data", tx_data, 16'h5A);
        wr(3'd0, 8'hA5);
        check("R8 tx full drop", tx_data, 16'h5A);
        rd(3'd5, v); check("R11 lsr tx busy", v, 16'h00);
        tx_take(v); check("R9 tx pop", v, 16'h5A);
        check("R9 tx empty", tx_valid, 0);

        rx_push(8'h11);
        rx_push(8'h22);
        rd(3'd5, v); check("R8 overrun lsr", v, 16'h23);
        rd(3'd5, v); check("R11 lsr cleared", v, 16'h21);
        rd(3'd0, v); check("R1 rx read", v, 16'h11);
        rd(3'd5, v); check("R1 rx popped", v, 16'h20);

        // R6 FIFO mode, transmit queue depth and order
        wr(3'd2, 8'h01);
        for (int i = 0; i < 16; i++) wr(3'd0, 8'((i * 37 + 5) & 255));
        wr(3'd0, 8'hEE);
        for (int i = 0; i < 16; i++) begin
            tx_take(v);
            check("R6 tx order", v, 16'((i * 37 + 5) & 255));
        end
        check("R9 tx drained", tx_valid, 0);

        // R6 receive queue depth and overrun at 17th byte
        for (int i = 0; i < 17; i++) rx_push(8'((i * 53 + 11) & 255));
        rd(3'd5, v); check("R8 fifo overrun", v, 16'h23);
        for (int i = 0; i < 16; i++) begin
            rd(3'd0, v);
            check("R6 rx order", v, 16'((i * 53 + 11) & 255));
        end
        rd(3'd5, v); check("R6 rx empty", v, 16'h20);

        // R6 flush on disable
        for (int i = 0; i < 5; i++) wr(3'd0, 8'(i));
        for (int i = 0; i < 5; i++) rx_push(8'(i));
        wr(3'd2, 8'h00);
        check("R6 tx flushed", tx_valid, 0);
        rd(3'd5, v); check("R6 rx flushed", v, 16'h20);

        // R7 trigger levels, received data available interrupt
        wr(3'd2, 8'h01);
        wr(3'd1, 8'h01);
        for (int code = 0; code < 4; code++) begin
            wr(3'd2, 8'((code << 6) | 1));
            for (int n = 1; n <= 15; n++) begin
                rx_push(8'(n));
                check("R7 trigger irq", irq, (n >= trig_of(code)) ? 1 : 0);
            end
            for (int n = 0; n < 15; n++) rd(3'd0, v);
            check("R7 drained irq", irq, 0);
        end

        // R4 R10 transmit holding empty interrupt
        wr(3'd1, 8'h02);
        check("R10 thre pending", irq, 1);
        rd(3'd2, v); check("R5 iir irq active", v, 16'hC0);
        wr(3'd0, 8'h77);
        check("R10 thre cleared", irq, 0);
        tx_take(v);
        check("R10 thre set on drain", irq, 1);

        // R4 line error masked versus enabled
        wr(3'd1, 8'h00);
        @(negedge clk); rx_err = 1'b1;
        @(negedge clk); rx_err = 1'b0;
        check("R4 masked irq", irq, 0);
        wr(3'd1, 8'h04);
        check("R4 line irq", irq, 1);
        rd(3'd5, v); check("R11 err bit", v, 16'h24);
        check("R4 line irq cleared", irq, 0);

        // R4 modem source
        modem_pend = 1'b1;
        @(negedge clk);
        check("R4 modem masked", irq, 0);
        wr(3'd1, 8'h08);
        check("R4 modem irq", irq, 1);
        modem_pend = 1'b0;
        @(negedge clk);
        check("R4 modem gone", irq, 0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule